// File: doc/BRIEF.md
# Motor PWM Output Channel with Recirculation Control

This block drives one pair of motor driver pins from a free-running frame timer. Every clock is one PWM clock. The timer counts from zero up to the programmed period minus one and then wraps. A 16-bit duty word sets two things: a magnitude that gives how many clocks per frame the active pin spends at its "on" level, and a sign that picks which pin of the pair carries the waveform. The recirculation bit sets the polarity. When it is clear, the duty counts low time. When it is set, the duty counts high time.

All settings are captured in shadow registers at each timer wrap, so a frame always runs with one consistent set of settings. A programmable skew of 0 to 3 clocks shifts the channel's edges. When the channel is switched off, or the period is set to zero, the pins are handed back at the next wrap. The block does this at once, without the skew, and raises a release flag so that the pad driver can be tri-stated.

Top module: `mpwm_channel`

## Requirements
- R1: The frame counter runs 0..period-1. `frame_start` is high for exactly the one cycle in which the counter has just wrapped to 0, so in steady state it pulses once every `period` cycles. With `period` = 0 the counter wraps on every cycle.
- R2: With `fast_mode` = 0, the duty magnitude is `duty_word[10:0]` and the sign is `duty_word[15]`. Bits 14..11 are ignored.
- R3: With `fast_mode` = 1, the duty magnitude is `duty_word[15:8]` and the sign is `duty_word[7]`. Bits 6..0 are ignored.
- R4: For a magnitude d with 0 < d < period, the carrying pin runs as follows. It is low while the frame count is below d and high for the rest of the frame when `recirc` = 0. It is high while the count is below d and low otherwise when `recirc` = 1.
- R5: A magnitude of 0 holds the carrying pin static high when `recirc` = 0 and static low when `recirc` = 1.
- R6: A magnitude greater than or equal to the period holds the carrying pin static low when `recirc` = 0 and static high when `recirc` = 1.
- R7: Sign 0 puts the waveform on `pin_a`. Sign 1 puts it on `pin_b`. The other pin holds the idle level, which is high when `recirc` = 0 and low when `recirc` = 1.
- R8: With skew k (`delay_sel`), the pins in a given cycle show the level belonging to the frame count k+1 cycles earlier. Skew 0 means one register of latency.
- R9: The duty word, `fast_mode`, `recirc`, `delay_sel` and `chan_en` are sampled only at a timer wrap. A change in the middle of a frame leaves the rest of that frame unchanged.
- R10: After reset, and after a wrap that samples `chan_en` = 0 or `period` = 0, `pin_release` is 1 and both pins are 0. This starts in the cycle after `frame_start` and ignores the skew. `pin_release` changes only in the cycle after `frame_start`.
- R11: While the channel is released, the skew stages are cleared. After re-enabling with skew k, both pins read 0 for the first k cycles in which `pin_release` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| period | input | 11 | Frame length in clocks; 0 requests release |
| chan_en | input | 1 | Channel enable request |
| fast_mode | input | 1 | Selects the 8-bit duty layout |
| recirc | input | 1 | Polarity: 0 duty counts low time, 1 high time |
| duty_word | input | 16 | Sign and duty magnitude image |
| delay_sel | input | 2 | Edge skew, 0..3 clocks |
| pin_a | output | 1 | First pin of the pair |
| pin_b | output | 1 | Second pin of the pair |
| pin_release | output | 1 | Pins handed back; driver may tri-state |
| frame_start | output | 1 | One-cycle pulse after each timer wrap |

## Verification
The assertions assume that `period` holds steady across the cycle in which `frame_start` is checked for a single-cycle pulse. They also assume that release changes are seen only at the port boundary. The bench changes `period` and the settings only at negedges, and it holds them for whole frames before it compares a frame. The one exception is the deliberate mid-frame edits that test shadowing and shutdown. Expected pin levels come from a model in the bench of the frame count, the skew and the duty rules. Samples are taken only in frames that both run and follow a frame with the same settings.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int MPWM_CNT_W  = 11;
  localparam int MPWM_WORD_W = 16;
  localparam int MPWM_FAST_W = 8;
  localparam int MPWM_DLY_W  = 2;

  // {pin_a, pin_b}
  typedef logic [1:0] pin_pair_t;
endpackage

// File: rtl/mpwm_timer.sv
module mpwm_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  // a zero period wraps every cycle so that release can proceed
  always_comb begin
    wrap = (period == '0) || (cnt_q >= period - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/mpwm_shadow.sv
module mpwm_shadow #(
  parameter int CNT_W  = 11,
  parameter int WORD_W = 16,
  parameter int FAST_W = 8,
  parameter int DLY_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] duty_word,
  input  logic              fast_mode,
  input  logic              recirc,
  input  logic [DLY_W-1:0]  delay_sel,
  input  logic              en_req,
  output logic [CNT_W-1:0]  sh_mag,
  output logic              sh_sign,
  output logic              sh_recirc,
  output logic [DLY_W-1:0]  sh_dly,
  output logic              sh_en
);
  localparam int FAST_SIGN_BIT = WORD_W - FAST_W - 1;

  logic [CNT_W-1:0] mag_dec;
  logic             sign_dec;

  always_comb begin
    if (fast_mode) begin
      mag_dec  = CNT_W'(duty_word[WORD_W-1 -: FAST_W]);
      sign_dec = duty_word[FAST_SIGN_BIT];
    end else begin
      mag_dec  = duty_word[CNT_W-1:0];
      sign_dec = duty_word[WORD_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_mag    <= '0;
      sh_sign   <= 1'b0;
      sh_recirc <= 1'b0;
      sh_dly    <= '0;
      sh_en     <= 1'b0;
    end else if (load) begin
      sh_mag    <= mag_dec;
      sh_sign   <= sign_dec;
      sh_recirc <= recirc;
      sh_dly    <= delay_sel;
      sh_en     <= en_req;
    end
  end
endmodule

// File: rtl/mpwm_wave.sv
module mpwm_wave
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] sh_mag,
  input  logic             sh_sign,
  input  logic             sh_recirc,
  input  logic [DLY_W-1:0] sh_dly,
  input  logic             sh_en,
  output logic             pin_a,
  output logic             pin_b,
  output logic             pin_release
);
  localparam int NSTG = (1 << DLY_W) - 1;

  logic      on_phase;
  logic      lvl;
  logic      idle_lvl;
  pin_pair_t pair_now;
  pin_pair_t stg_q [NSTG];
  pin_pair_t taps  [NSTG+1];
  pin_pair_t tap_sel;

  // the count never reaches the period, so d = 0 and d >= period fall out
  // of this compare as the two static levels
  always_comb begin
    on_phase = (cnt < sh_mag);
    idle_lvl = ~sh_recirc;
    lvl      = on_phase ? sh_recirc : ~sh_recirc;
    pair_now = sh_sign ? {idle_lvl, lvl} : {lvl, idle_lvl};
  end

  genvar gi;
  generate
    for (gi = 0; gi < NSTG; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst || !sh_en) stg_q[gi] <= '0;
          else               stg_q[gi] <= pair_now;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst || !sh_en) stg_q[gi] <= '0;
          else               stg_q[gi] <= stg_q[gi-1];
        end
      end
      assign taps[gi+1] = stg_q[gi];
    end
  endgenerate

  assign taps[0] = pair_now;
  assign tap_sel = taps[sh_dly];

  always_ff @(posedge clk) begin
    if (rst || !sh_en) begin
      pin_a       <= 1'b0;
      pin_b       <= 1'b0;
      pin_release <= 1'b1;
    end else begin
      pin_a       <= tap_sel[1];
      pin_b       <= tap_sel[0];
      pin_release <= 1'b0;
    end
  end
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel
  import mpwm_pkg::*;
#(
  parameter int CNT_W  = MPWM_CNT_W,
  parameter int WORD_W = MPWM_WORD_W,
  parameter int FAST_W = MPWM_FAST_W,
  parameter int DLY_W  = MPWM_DLY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  period,
  input  logic              chan_en,
  input  logic              fast_mode,
  input  logic              recirc,
  input  logic [WORD_W-1:0] duty_word,
  input  logic [DLY_W-1:0]  delay_sel,
  output logic              pin_a,
  output logic              pin_b,
  output logic              pin_release,
  output logic              frame_start
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CNT_W-1:0] sh_mag;
  logic             sh_sign;
  logic             sh_recirc;
  logic [DLY_W-1:0] sh_dly;
  logic             sh_en;
  logic             en_req;

  assign en_req = chan_en && (period != '0);

  mpwm_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .period(period),
    .cnt(cnt), .wrap(wrap), .ovf(frame_start)
  );

  mpwm_shadow #(
    .CNT_W(CNT_W), .WORD_W(WORD_W), .FAST_W(FAST_W), .DLY_W(DLY_W)
  ) shadow_i (
    .clk(clk), .rst(rst), .load(wrap),
    .duty_word(duty_word), .fast_mode(fast_mode), .recirc(recirc),
    .delay_sel(delay_sel), .en_req(en_req),
    .sh_mag(sh_mag), .sh_sign(sh_sign), .sh_recirc(sh_recirc),
    .sh_dly(sh_dly), .sh_en(sh_en)
  );

  mpwm_wave #(.CNT_W(CNT_W), .DLY_W(DLY_W)) wave_i (
    .clk(clk), .rst(rst), .cnt(cnt),
    .sh_mag(sh_mag), .sh_sign(sh_sign), .sh_recirc(sh_recirc),
    .sh_dly(sh_dly), .sh_en(sh_en),
    .pin_a(pin_a), .pin_b(pin_b), .pin_release(pin_release)
  );
endmodule

// File: rtl/mpwm_channel_chk.sv
module mpwm_channel_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] period,
  input logic             pin_a,
  input logic             pin_b,
  input logic             pin_release,
  input logic             frame_start
);
  AST_RELEASE_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
    pin_release |-> (!pin_a && !pin_b)); // R10

  AST_RELEASE_RISE_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_release) |-> $past(frame_start)); // R10

  AST_RELEASE_FALL_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_release) |-> $past(frame_start)); // R9

  AST_ZERO_PERIOD_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (period == '0) |=> frame_start); // R1

  AST_SINGLE_CYCLE_FRAME_PULSE: assert property (@(posedge clk) disable iff (rst)
    (frame_start && period > CNT_W'(1)) |=> !frame_start); // R1
endmodule

bind mpwm_channel mpwm_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .period(period), .pin_a(pin_a), .pin_b(pin_b),
  .pin_release(pin_release), .frame_start(frame_start)
);

// File: tb/mpwm_channel_tb_top.sv
module mpwm_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  typedef struct packed {
    logic [10:0] per;
    logic [15:0] word;
    logic        fast;
    logic        rec;
    logic [1:0]  dly;
    logic [5:0]  exp_a;
    logic [5:0]  exp_b;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{11'd10, 16'h0003, 1'b0, 1'b0, 2'd0, 6'd7,  6'd10}, // R4 basic low time
    '{11'd10, 16'h8003, 1'b0, 1'b0, 2'd1, 6'd10, 6'd7},  // R7 sign swaps pins
    '{11'd10, 16'h0004, 1'b0, 1'b1, 2'd2, 6'd4,  6'd0},  // R4 high time
    '{11'd10, 16'h0000, 1'b0, 1'b0, 2'd0, 6'd10, 6'd10}, // R5 zero, high
    '{11'd10, 16'h0000, 1'b0, 1'b1, 2'd3, 6'd0,  6'd0},  // R5 zero, low
    '{11'd10, 16'h000A, 1'b0, 1'b0, 2'd0, 6'd0,  6'd10}, // R6 equal period
    '{11'd10, 16'h07FF, 1'b0, 1'b1, 2'd1, 6'd10, 6'd0},  // R6 above period
    '{11'd20, 16'h0580, 1'b1, 1'b0, 2'd3, 6'd20, 6'd15}, // R3 fast, sign bit 7
    '{11'd20, 16'h0C7F, 1'b1, 1'b1, 2'd1, 6'd12, 6'd0},  // R3 low bits ignored
    '{11'd16, 16'h7805, 1'b0, 1'b0, 2'd1, 6'd11, 6'd16}, // R2 bits 14..11 ignored
    '{11'd1,  16'h0001, 1'b0, 1'b0, 2'd0, 6'd0,  6'd1}   // R6 period of one
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [10:0] period;
  logic        chan_en;
  logic        fast_mode;
  logic        recirc;
  logic [15:0] duty_word;
  logic [1:0]  delay_sel;
  logic        pin_a, pin_b, pin_release, frame_start;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpwm_channel dut_i (
    .clk(clk), .rst(rst), .period(period), .chan_en(chan_en),
    .fast_mode(fast_mode), .recirc(recirc), .duty_word(duty_word),
    .delay_sel(delay_sel), .pin_a(pin_a), .pin_b(pin_b),
    .pin_release(pin_release), .frame_start(frame_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (!frame_start);
  endtask

  // expected {pin_a,pin_b} for the count position c, built from R2..R7
  function automatic logic [1:0] ref_pair(input int c, input logic [15:0] w,
                                          input logic f, input logic r);
    int d;
    logic s, lv, idl;
    if (f) begin d = int'(w[15:8]); s = w[7]; end
    else   begin d = int'(w[10:0]); s = w[15]; end
    idl = ~r;
    lv  = (c < d) ? r : ~r;
    return s ? {idl, lv} : {lv, idl};
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
        summary();
      end
    end
  end

  initial begin
    int p, k, mism, cnt_a, cnt_b, j, gap;
    logic [1:0] e;
    rst = 1'b1; period = 11'd10; chan_en = 1'b1; fast_mode = 1'b0;
    recirc = 1'b0; duty_word = 16'h0003; delay_sel = 2'd0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(pin_release == 1'b1, "R10 release in reset", pin_release, 1);
    check({pin_a, pin_b} == 2'b00, "R10 pins low in reset", {pin_a, pin_b}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(pin_release == 1'b1, "R10 release held before first wrap", pin_release, 1);

    // table walk: R2..R8
    for (int v = 0; v < NVEC; v++) begin
      period = VECS[v].per; duty_word = VECS[v].word; fast_mode = VECS[v].fast;
      recirc = VECS[v].rec; delay_sel = VECS[v].dly;
      wait_frame();
      wait_frame();
      p = int'(VECS[v].per); k = int'(VECS[v].dly);
      mism = 0; cnt_a = 0; cnt_b = 0;
      for (int jj = 0; jj < p; jj++) begin
        e = ref_pair((((jj - 1 - k) % p) + p) % p, VECS[v].word, VECS[v].fast, VECS[v].rec);
        if ({pin_a, pin_b} != e || pin_release) mism++;
        cnt_a += int'(pin_a); cnt_b += int'(pin_b);
        @(negedge clk);
      end
      check(mism == 0, $sformatf("R8 R4 per-cycle pattern vec %0d", v), mism, 0);
      check(cnt_a == int'(VECS[v].exp_a), $sformatf("R7 pin_a high count vec %0d", v),
            cnt_a, int'(VECS[v].exp_a));
      check(cnt_b == int'(VECS[v].exp_b), $sformatf("R7 pin_b high count vec %0d", v),
            cnt_b, int'(VECS[v].exp_b));
    end

    // R1 frame spacing
    period = 11'd5;
    wait_frame(); wait_frame();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!frame_start);
    check(gap == 5, "R1 frame_start spacing", gap, 5);

    // R9 mid-frame edit is shadowed
    period = 11'd10; duty_word = 16'h0003; fast_mode = 1'b0; recirc = 1'b0; delay_sel = 2'd0;
    wait_frame(); wait_frame();
    duty_word = 16'h0008;
    mism = 0;
    for (j = 1; j < 10; j++) begin
      @(negedge clk);
      e = ref_pair(j - 1, 16'h0003, 1'b0, 1'b0);
      if ({pin_a, pin_b} != e) mism++;
    end
    check(mism == 0, "R9 old duty kept to end of frame", mism, 0);
    wait_frame();
    repeat (5) @(negedge clk);
    check(pin_a == 1'b0, "R9 new duty applied next frame", pin_a, 0);

    // R10 disable releases at the next wrap, without skew
    duty_word = 16'h0003; delay_sel = 2'd3;
    wait_frame(); wait_frame();
    repeat (3) @(negedge clk);
    chan_en = 1'b0;
    @(negedge clk);
    check(pin_release == 1'b0, "R10 no release mid-frame", pin_release, 0);
    wait_frame();
    check(pin_release == 1'b0, "R10 release not yet at frame_start", pin_release, 0);
    @(negedge clk);
    check(pin_release == 1'b1, "R10 release one cycle after wrap", pin_release, 1);
    check({pin_a, pin_b} == 2'b00, "R10 pins low at once despite skew", {pin_a, pin_b}, 0);

    // R11 re-enable with skew 3: pins read 0 for three cycles
    chan_en = 1'b1;
    wait_frame();
    @(negedge clk);
    check(pin_release == 1'b0, "R11 release drops after wrap", pin_release, 0);
    mism = 0;
    for (j = 1; j <= 3; j++) begin
      if ({pin_a, pin_b} != 2'b00) mism++;
      @(negedge clk);
    end
    check(mism == 0, "R11 cleared skew stages", mism, 0);
    check({pin_a, pin_b} == 2'b01, "R11 first real sample", {pin_a, pin_b}, 1);

    // R10 / R1 cleared period
    period = 11'd0;
    repeat (3) @(negedge clk);
    check(pin_release == 1'b1, "R10 release on zero period", pin_release, 1);
    check(frame_start == 1'b1, "R1 zero period wraps", frame_start, 1);
    @(negedge clk);
    check(frame_start == 1'b1, "R1 zero period wraps every cycle", frame_start, 1);

    done = 1'b1;
    summary();
  end
endmodule